// File: doc/BRIEF.md
# Haltable Timekeeper Register Snapshot

This block keeps calendar time in BCD counters that advance once per second. The tick comes from a prescaler fed by a 32,768 Hz oscillator strobe. Software never reads the counters directly. It reads a bank of eight byte-wide registers at the very top of a 17-bit byte address space. Those registers hold a copy of the counters, and every field of the copy is replaced together on the same clock edge.

A control byte at the lowest of the eight addresses carries a freeze bit. While that bit is set, the copy stops changing, so software can read every field without tearing. The counters keep running in the meantime. Clearing the bit does not resume the copy at once. The copy is refreshed exactly one second of oscillator time after the clear, and the regular per-second refreshes take over from there.

Writing a time field loads the matching counter. Writing the seconds field also restarts the prescaler, so the next second starts from that write. The block ignores any address below the timekeeper window.

Top module: `rtc_snapshot`

## Requirements
- R1: After reset the control byte reads 0x00, and the copy reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00.
- R2: Address 0x1FFF8 plus offset k selects the control byte for k=0, then seconds, minutes, hours, weekday, date, month and year for k=1..7. In the control byte only bit 6, the freeze bit, is stored and read back. Every other control bit reads 0.
- R3: The seconds counter advances once per 2^PRESC_BITS oscillator strobes. A write to the seconds field clears the prescaler, so the next advance comes after a full 2^PRESC_BITS strobes.
- R4: Seconds and minutes count 00..59 and hours count 00..23, all in BCD. The weekday counts 1..7 and wraps to 1 when the date advances.
- R5: The date counts up to the month's length in BCD: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the BCD year is divisible by four and 28 otherwise. Month 12 wraps to 01, and year 99 wraps to 00.
- R6: A write to a time field loads the counter at once. The visible copy shows the new value only at its next refresh.
- R7: While the freeze bit is 1, the copy holds the time current when the freeze was written, and the counters keep advancing.
- R8: When the freeze write falls in the same cycle as a second tick, that tick's refresh still completes, and the copy shows the new second.
- R9: After the freeze bit is cleared, the copy is refreshed exactly 2^PRESC_BITS strobes later with the current counter values. Ticks that fall inside that window do not refresh the copy.
- R10: With chip enable low, or with an address below 0x1FFF8, reads return 0x00 and writes change nothing.
- R11: Every field of the copy changes on the same edge, and only on a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_en | input | 1 | One-cycle strobe per oscillator period |
| cs | input | 1 | Chip enable |
| we | input | 1 | Write enable, qualified by cs |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |

## Verification
The hardest case to reach is a release whose one-second wait straddles a regular tick. The counters move inside the window, but the copy must not. To reach it, the stimulus sets the freeze, then runs a strobe count that leaves the prescaler mid-period, and then clears the freeze. Reads taken after the intermediate tick and again at the end of the window show both the suppression and the late refresh. The same strobe-precise control lets a freeze write share its cycle with a tick.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                      dow: 8'h01, hr: 8'h00, min: 8'h00,
                                      sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Divisibility by four of a two-digit BCD year: (2*tens + ones) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return s[1:0] == 2'd0;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) n.min = bcd_inc(t.min);
      else begin
        n.min = 8'h00;
        if (t.hr != 8'h23) n.hr = bcd_inc(t.hr);
        else begin
          n.hr  = 8'h00;
          n.dow = (t.dow == 8'h07) ? 8'h01 : t.dow + 8'd1;
          if (t.date != month_len(t.mon, t.yr)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
            else begin
              n.mon = 8'h01;
              n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] field_at(input rtc_time_t t, input logic [2:0] off);
    case (off)
      3'd1:    return t.sec;
      3'd2:    return t.min;
      3'd3:    return t.hr;
      3'd4:    return t.dow;
      3'd5:    return t.date;
      3'd6:    return t.mon;
      3'd7:    return t.yr;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic clr,
  output logic tick
);
  logic [PRESC_BITS-1:0] cnt_q;

  assign tick = osc_en && !clr && (cnt_q == {PRESC_BITS{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (osc_en) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_snap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output rtc_time_t  cur,
  output rtc_time_t  nxt
);
  rtc_time_t adv;

  always_comb begin
    adv = tick ? advance(cur) : cur;
    nxt = adv;
    if (ld_en) begin
      case (ld_sel)
        3'd1:    nxt.sec  = ld_data;
        3'd2:    nxt.min  = ld_data;
        3'd3:    nxt.hr   = ld_data;
        3'd4:    nxt.dow  = ld_data;
        3'd5:    nxt.date = ld_data;
        3'd6:    nxt.mon  = ld_data;
        3'd7:    nxt.yr   = ld_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RTC_RESET;
    else        cur <= nxt;
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_snap_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_en,
  input  logic      tick,
  input  logic      ctl_we,
  input  logic      ctl_freeze,
  input  rtc_time_t cal_nxt,
  output rtc_time_t vis,
  output logic      freeze_q,
  output logic      hold_active,
  output logic      hold_done,
  output logic      refresh_evt
);
  localparam int HOLD_W = PRESC_BITS + 1;
  localparam logic [HOLD_W-1:0] HOLD_FULL = {1'b1, {PRESC_BITS{1'b0}}};

  logic [HOLD_W-1:0] hold_cnt;
  logic              release_evt;

  assign release_evt = ctl_we && freeze_q && !ctl_freeze;
  assign hold_done   = hold_active && osc_en && (hold_cnt == HOLD_W'(1));
  assign refresh_evt = !freeze_q && (hold_active ? hold_done : tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q    <= 1'b0;
      hold_active <= 1'b0;
      hold_cnt    <= '0;
      vis         <= RTC_RESET;
    end else begin
      if (ctl_we) freeze_q <= ctl_freeze;
      if (ctl_we && ctl_freeze) begin
        hold_active <= 1'b0;
      end else if (release_evt) begin
        hold_active <= 1'b1;
        hold_cnt    <= HOLD_FULL;
      end else if (hold_done) begin
        hold_active <= 1'b0;
      end else if (hold_active && osc_en) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      if (refresh_evt) vis <= cal_nxt;
    end
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PRESC_BITS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int FREEZE_BIT = 6;

  logic       in_window, wr_hit, ctl_we, ld_en, sec_clr, sec_tick;
  logic [2:0] off;
  logic       freeze_q, hold_active, hold_done, refresh_evt;
  logic       unused_wbits;
  rtc_time_t  cal_cur, cal_nxt, vis;

  assign in_window    = cs && (addr[ADDR_W-1:3] == {(ADDR_W-3){1'b1}});
  assign off          = addr[2:0];
  assign wr_hit       = in_window && we;
  assign ctl_we       = wr_hit && (off == 3'd0);
  assign ld_en        = wr_hit && (off != 3'd0);
  assign sec_clr      = ld_en && (off == 3'd1);
  assign unused_wbits = ^{wdata[7], wdata[5:0]};

  rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clr(sec_clr), .tick(sec_tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .ld_en(ld_en), .ld_sel(off),
    .ld_data(wdata), .cur(cal_cur), .nxt(cal_nxt)
  );

  rtc_shadow #(.PRESC_BITS(PRESC_BITS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick(sec_tick),
    .ctl_we(ctl_we), .ctl_freeze(wdata[FREEZE_BIT]), .cal_nxt(cal_nxt),
    .vis(vis), .freeze_q(freeze_q), .hold_active(hold_active),
    .hold_done(hold_done), .refresh_evt(refresh_evt)
  );

  always_comb begin
    if (!in_window)       rdata = 8'h00;
    else if (off == 3'd0) rdata = {1'b0, freeze_q, 6'b0};
    else                  rdata = field_at(vis, off);
  end
endmodule

// File: rtl/rtc_snapshot_chk.sv
module rtc_snapshot_chk
  import rtc_snap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       freeze_q,
  input logic       hold_active,
  input logic       hold_done,
  input logic       refresh_evt,
  input logic [7:0] cur_sec,
  input logic [7:0] cur_mon,
  input rtc_time_t  cal_nxt,
  input rtc_time_t  vis
);
  AST_FROZEN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |=> $stable(vis)); // R7
  AST_CHANGE_NEEDS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vis) |-> $past(refresh_evt)); // R11
  AST_WHOLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_evt |=> (vis == $past(cal_nxt))); // R11
  AST_TICK_BEATS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze_q && !hold_active) |-> refresh_evt); // R8
  AST_HOLD_MASKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !hold_done) |-> !refresh_evt); // R9
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sec[3:0] <= 4'd9) && (cur_sec < 8'h60)); // R4
  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mon >= 8'h01) && (cur_mon <= 8'h12)); // R5
endmodule

bind rtc_snapshot rtc_snapshot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(sec_tick), .freeze_q(freeze_q),
  .hold_active(hold_active), .hold_done(hold_done), .refresh_evt(refresh_evt),
  .cur_sec(cal_cur.sec), .cur_mon(cal_cur.mon), .cal_nxt(cal_nxt), .vis(vis)
);

// File: tb/rtc_snapshot_tb.sv
module rtc_snapshot_tb;
  localparam int PB  = 4;
  localparam int SEC = 1 << PB;
  localparam logic [16:0] BASE = 17'h1FFF8;

  logic clk = 0, rst_n = 0, osc_en = 0, cs = 0, we = 0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_snapshot #(.ADDR_W(17), .PRESC_BITS(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic osc, input logic sel);
    @(negedge clk);
    cs = sel; we = 1; addr = a; wdata = d; osc_en = osc;
    @(negedge clk);
    cs = 0; we = 0; osc_en = 0;
  endtask

  task automatic rd(input logic [16:0] a, input logic sel, output logic [7:0] v);
    @(negedge clk);
    cs = sel; we = 0; addr = a;
    #1 v = rdata;
    cs = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1;
      @(negedge clk); osc_en = 0;
    end
  endtask

  task automatic set_time(input logic [7:0] yr, mon, date, dow, hr, mn, sc);
    wr(BASE + 7, yr, 0, 1);  wr(BASE + 6, mon, 0, 1); wr(BASE + 5, date, 0, 1);
    wr(BASE + 4, dow, 0, 1); wr(BASE + 3, hr, 0, 1);  wr(BASE + 2, mn, 0, 1);
    wr(BASE + 1, sc, 0, 1);
  endtask

  task automatic chk_time(input string tag, input logic [7:0] yr, mon, date, dow, hr, mn, sc);
    logic [7:0] v;
    rd(BASE + 1, 1, v); chk({tag, " sec"}, v, sc);
    rd(BASE + 2, 1, v); chk({tag, " min"}, v, mn);
    rd(BASE + 3, 1, v); chk({tag, " hour"}, v, hr);
    rd(BASE + 4, 1, v); chk({tag, " dow"}, v, dow);
    rd(BASE + 5, 1, v); chk({tag, " date"}, v, date);
    rd(BASE + 6, 1, v); chk({tag, " month"}, v, mon);
    rd(BASE + 7, 1, v); chk({tag, " year"}, v, yr);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(BASE, 1, v); chk("R1 control", v, 8'h00);
    chk_time("R1 reset", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(BASE, 8'hFF, 0, 1);
    rd(BASE, 1, v); chk("R2 only freeze bit stored", v, 8'h40);
    wr(BASE, 8'h00, 0, 1);
    rd(BASE, 1, v); chk("R2 freeze cleared", v, 8'h00);
    pulses(SEC);
  endtask

  task automatic t_prescale;
    logic [7:0] v;
    set_time(8'h21, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h29);
    pulses(SEC);
    rd(BASE + 1, 1, v); chk("R3 first tick", v, 8'h30);
    wr(BASE + 1, 8'h45, 0, 1);
    rd(BASE + 1, 1, v); chk("R6 load not yet visible", v, 8'h30);
    pulses(SEC - 1);
    rd(BASE + 1, 1, v); chk("R3 prescaler cleared by seconds write", v, 8'h30);
    pulses(1);
    rd(BASE + 1, 1, v); chk("R6 loaded value advanced", v, 8'h46);
    rd(BASE + 2, 1, v); chk("R6 minutes loaded", v, 8'h20);
  endtask

  task automatic t_rollover;
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R4 R5 R11 full wrap", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h05, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R4 hour carry", 8'h21, 8'h05, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic t_months;
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00);
    set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 leap feb end", 8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 common feb end", 8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
    set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 year 00 leap", 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 30-day month", 8'h21, 8'h05, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h01, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    chk_time("R5 31-day month", 8'h21, 8'h02, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_freeze;
    logic [7:0] v;
    set_time(8'h22, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h00);
    pulses(SEC);
    rd(BASE + 1, 1, v); chk("R7 before freeze", v, 8'h01);
    wr(BASE, 8'h40, 0, 1);
    pulses(2 * SEC + SEC / 2);
    rd(BASE + 1, 1, v); chk("R7 frozen copy", v, 8'h01);
    rd(BASE, 1, v);     chk("R7 freeze bit reads 1", v, 8'h40);
    wr(BASE, 8'h00, 0, 1);
    pulses(SEC / 2);
    rd(BASE + 1, 1, v); chk("R9 tick inside window masked", v, 8'h01);
    pulses(SEC / 2 - 1);
    rd(BASE + 1, 1, v); chk("R9 one strobe short", v, 8'h01);
    pulses(1);
    rd(BASE + 1, 1, v); chk("R7 R9 release refresh shows running count", v, 8'h04);
    pulses(SEC / 2);
    rd(BASE + 1, 1, v); chk("R9 regular refresh resumes", v, 8'h05);
    wr(BASE, 8'h00, 0, 1);
  endtask

  task automatic t_coincide;
    logic [7:0] v;
    set_time(8'h22, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h10);
    pulses(SEC - 1);
    wr(BASE, 8'h40, 1, 1);
    rd(BASE + 1, 1, v); chk("R8 tick completes with freeze", v, 8'h11);
    pulses(SEC);
    rd(BASE + 1, 1, v); chk("R8 then frozen", v, 8'h11);
    wr(BASE, 8'h00, 0, 1);
    pulses(SEC);
    rd(BASE + 1, 1, v); chk("R9 release at tick phase", v, 8'h13);
  endtask

  task automatic t_outside;
    logic [7:0] v;
    set_time(8'h22, 8'h07, 8'h04, 8'h01, 8'h12, 8'h00, 8'h20);
    pulses(SEC);
    wr(17'h1FFF7, 8'h55, 0, 1);
    rd(17'h1FFF7, 1, v); chk("R10 below window reads 0", v, 8'h00);
    wr(17'h00009, 8'h45, 0, 1);
    wr(BASE + 1, 8'h50, 0, 0);
    rd(BASE + 1, 0, v);  chk("R10 cs low reads 0", v, 8'h00);
    pulses(SEC);
    rd(BASE + 1, 1, v);  chk("R10 ignored writes", v, 8'h22);
    rd(BASE, 1, v);      chk("R10 control untouched", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_map;
    t_prescale;
    t_rollover;
    t_months;
    t_freeze;
    t_coincide;
    t_outside;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule